// File: doc/BRIEF.md
# Configuration Mode Unlock Sequencer

This block snoops byte writes on an I/O write interface and decides when a peripheral controller may enter its configuration state. Entry takes two stages. In the first stage, four bytes go to a fixed unlock port. Two of them are a fixed lead-in and the other two are a selector that picks one of three base addresses. In the second stage, a 32-byte key must be written in order to the base address that was picked. Once the last key byte is accepted, the block raises its configuration flag. The base port and the port above it then act as the index and data ports of the register bank.

The register bank ends configuration mode with a one-cycle exit pulse. Reset has the same effect. The exit pulse also drops any partly matched sequence. Read cycles are not observed. Every output is registered.

Top module: `cfg_unlock_seq`

## Requirements
- R1: After reset is asserted (synchronous, active high), cfg_active is 0 and base_addr is 16'h0000, whatever state the block was in before.
- R2: A write of 0x86, then 0x80, then two selector bytes to port 0x279 chooses the base. Selector 0x55,0x55 gives 0x03F0, 0x55,0xAA gives 0x03BD, and 0xAA,0x55 gives 0x0370. base_addr shows the choice from the cycle after the fourth byte, and cfg_active stays 0.
- R3: The selector pair 0xAA,0xAA is not valid. It returns the sequencer to waiting for 0x86, and base_addr stays 0x0000.
- R4: A byte on port 0x279 that does not match the expected preamble byte restarts the preamble. If that byte is 0x86, it counts as the first preamble byte.
- R5: During the preamble, only writes to 0x279 are compared. During the key stage, only writes to the selected base are compared. Writes to any other port, including base+1 and 0x279 during the key stage, and cycles with io_wr low, leave the progress unchanged.
- R6: The key is 6A B5 DA ED F6 FB 7D BE DF 6F 37 1B 0D 86 C3 61 B0 58 2C 16 8B 45 A2 D1 E8 74 3A 9D CE E7 73 39, written in that order to the selected base. cfg_active becomes 1 in the cycle after the 32nd correct byte, and not before.
- R7: A wrong byte written to the selected base during the key stage sets base_addr back to 0x0000 and the sequencer back to waiting for the preamble. This holds at any key position, including the last one.
- R8: While cfg_active is 1, no write changes cfg_active or base_addr.
- R9: A cfg_exit pulse clears cfg_active and base_addr in the next cycle. It also drops a partial preamble or a partial key, so the remaining bytes alone cannot unlock the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_addr | input | 16 | I/O port address of the write |
| io_data | input | 8 | Byte written |
| cfg_exit | input | 1 | Exit pulse from the register bank |
| cfg_active | output | 1 | Configuration state granted |
| base_addr | output | 16 | Selected base port, 0 when no base is selected |

## Verification
The bench goes after the resync case, where a stray 0x86 arrives in the middle of the preamble. A design that discards that byte would need a fresh lead-in and would miss the unlock that follows. It also sends the invalid 0xAA,0xAA selector; a design that decodes selectors loosely would latch a base. Key bytes are interleaved with writes to base+1 and to the unlock port, which a design comparing every write would treat as errors. A wrong final key byte is sent, which catches a count that grants the unlock one byte early. An exit pulse in the middle of the key is followed by the remaining key bytes, which catches a design that keeps its position across the exit.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;

  typedef enum logic [1:0] {
    STG_PRE = 2'd0,
    STG_KEY = 2'd1,
    STG_CFG = 2'd2
  } stage_e;

  // One step of the key generator: shift right, feed back bit0 ^ bit1.
  function automatic logic [7:0] key_step(input logic [7:0] k);
    return {k[0] ^ k[1], k[7:1]};
  endfunction

  // Key byte at position n, computed from the seed.
  function automatic logic [7:0] key_at(input int unsigned n, input logic [7:0] seed);
    logic [7:0] k;
    k = seed;
    for (int unsigned i = 0; i < 256; i++) begin
      if (i < n) k = key_step(k);
    end
    return k;
  endfunction

endpackage

// File: rtl/cfgu_preamble.sv
module cfgu_preamble #(
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  LEAD0  = 8'h86,
  parameter logic [7:0]  LEAD1  = 8'h80,
  parameter logic [7:0]  SEL_LO = 8'h55,
  parameter logic [7:0]  SEL_HI = 8'hAA,
  parameter logic [15:0] BASE_A = 16'h03F0,
  parameter logic [15:0] BASE_B = 16'h03BD,
  parameter logic [15:0] BASE_C = 16'h0370
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              armed,
  input  logic              hit,
  input  logic [DATA_W-1:0] data,
  output logic              done,
  output logic [ADDR_W-1:0] done_base
);

  localparam int STEPS = 4;
  localparam int IDX_W = $clog2(STEPS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

  logic [IDX_W-1:0] idx;
  logic             sel0_hi;
  logic             ok;
  logic             take;

  assign take = armed && hit;

  always_comb begin
    ok        = 1'b0;
    done_base = '0;
    case (idx)
      IDX_W'(0): ok = (data == LEAD0);
      IDX_W'(1): ok = (data == LEAD1);
      IDX_W'(2): ok = (data == SEL_LO) || (data == SEL_HI);
      default: begin
        ok = (data == SEL_LO) || (data == SEL_HI && !sel0_hi);
        if (!sel0_hi && data == SEL_LO)     done_base = ADDR_W'(BASE_A);
        else if (!sel0_hi)                  done_base = ADDR_W'(BASE_B);
        else                                done_base = ADDR_W'(BASE_C);
      end
    endcase
  end

  assign done = take && ok && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx     <= '0;
      sel0_hi <= 1'b0;
    end else if (take) begin
      if (ok) begin
        idx <= (idx == LAST) ? '0 : idx + 1'b1;
        if (idx == IDX_W'(2)) sel0_hi <= (data == SEL_HI);
      end else begin
        idx <= (data == LEAD0) ? IDX_W'(1) : '0;
      end
    end
  end

  // Preamble progress only moves while its stage is active.
  p_idle_when_disarmed_r5: assert property (@(posedge clk) disable iff (rst)
    (!armed && !take) |=> (idx == '0 || armed));

endmodule

// File: rtl/cfgu_key_track.sv
module cfgu_key_track #(
  parameter int         DATA_W   = 8,
  parameter int         KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A,
  parameter int         KEY_MODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              armed,
  input  logic              hit,
  input  logic [DATA_W-1:0] data,
  output logic              good,
  output logic              bad,
  output logic              last
);
  import cfgu_pkg::*;

  localparam int CNT_W = $clog2(KEY_LEN);
  localparam logic [CNT_W-1:0] POS_END = CNT_W'(KEY_LEN - 1);

  logic [CNT_W-1:0] pos;
  logic [7:0]       expect_b;
  logic             take;

  assign take = armed && hit;
  assign good = take && (data == DATA_W'(expect_b));
  assign bad  = take && !good;
  assign last = good && (pos == POS_END);

  generate
    if (KEY_MODE == 0) begin : g_run
      // Running generator register: one step of logic per byte.
      logic [7:0] cur;
      always_ff @(posedge clk) begin
        if (rst || clear || bad || last) cur <= KEY_SEED;
        else if (good)                   cur <= key_step(cur);
      end
      assign expect_b = cur;
    end else begin : g_calc
      // Key byte computed from the position each cycle.
      assign expect_b = key_at(int'(pos), KEY_SEED);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear || bad || last) pos <= '0;
    else if (good)                   pos <= pos + 1'b1;
  end

  // Key position is parked at zero outside the key stage.
  p_pos_parked_r7: assert property (@(posedge clk) disable iff (rst)
    (bad || clear) |=> (pos == '0));

endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] PNP_PORT = 16'h0279,
  parameter logic [15:0] BASE_A   = 16'h03F0,
  parameter logic [15:0] BASE_B   = 16'h03BD,
  parameter logic [15:0] BASE_C   = 16'h0370,
  parameter int          KEY_LEN  = 32,
  parameter logic [7:0]  KEY_SEED = 8'h6A,
  parameter int          KEY_MODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_data,
  input  logic              cfg_exit,
  output logic              cfg_active,
  output logic [ADDR_W-1:0] base_addr
);
  import cfgu_pkg::*;

  stage_e            stage;
  logic              hit_pre, hit_key;
  logic              pre_done;
  logic [ADDR_W-1:0] pre_base;
  logic              key_good, key_bad, key_last;

  assign hit_pre = io_wr && (io_addr == ADDR_W'(PNP_PORT));
  assign hit_key = io_wr && (io_addr == base_addr);

  cfgu_preamble #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BASE_A(BASE_A), .BASE_B(BASE_B), .BASE_C(BASE_C)
  ) u_pre (
    .clk(clk), .rst(rst), .clear(cfg_exit),
    .armed(stage == STG_PRE), .hit(hit_pre), .data(io_data),
    .done(pre_done), .done_base(pre_base)
  );

  cfgu_key_track #(
    .DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .KEY_SEED(KEY_SEED), .KEY_MODE(KEY_MODE)
  ) u_key (
    .clk(clk), .rst(rst), .clear(cfg_exit),
    .armed(stage == STG_KEY), .hit(hit_key), .data(io_data),
    .good(key_good), .bad(key_bad), .last(key_last)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_exit) begin
      stage      <= STG_PRE;
      base_addr  <= '0;
      cfg_active <= 1'b0;
    end else begin
      case (stage)
        STG_PRE: if (pre_done) begin
          stage     <= STG_KEY;
          base_addr <= pre_base;
        end
        STG_KEY: begin
          if (key_last) begin
            stage      <= STG_CFG;
            cfg_active <= 1'b1;
          end else if (key_bad) begin
            stage     <= STG_PRE;
            base_addr <= '0;
          end
        end
        default: stage <= STG_CFG;
      endcase
    end
  end

  p_unlock_next_r6: assert property (@(posedge clk) disable iff (rst)
    (stage == STG_KEY && key_last && !cfg_exit) |=> cfg_active);

  p_rise_after_key_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_active) |-> $past(key_last));

  p_exit_clears_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_exit |=> (!cfg_active && base_addr == '0));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_active && !cfg_exit) |=> (cfg_active && $stable(base_addr)));

  p_base_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (base_addr != '0) |-> (base_addr == ADDR_W'(BASE_A) ||
                           base_addr == ADDR_W'(BASE_B) ||
                           base_addr == ADDR_W'(BASE_C)));

  p_key_only_in_stage_r5: assert property (@(posedge clk) disable iff (rst)
    (key_good && !cfg_exit && !key_last) |=> (base_addr == $past(base_addr)));

endmodule

// File: tb/cfg_unlock_seq_test.sv
module cfg_unlock_seq_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic        cfg_exit = 1'b0;
  logic        cfg_active;
  logic [15:0] base_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  cfg_unlock_seq uut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .cfg_exit(cfg_exit), .cfg_active(cfg_active), .base_addr(base_addr)
  );

  localparam logic [7:0] KEY [0:31] = '{
    8'h6A, 8'hB5, 8'hDA, 8'hED, 8'hF6, 8'hFB, 8'h7D, 8'hBE,
    8'hDF, 8'h6F, 8'h37, 8'h1B, 8'h0D, 8'h86, 8'hC3, 8'h61,
    8'hB0, 8'h58, 8'h2C, 8'h16, 8'h8B, 8'h45, 8'hA2, 8'hD1,
    8'hE8, 8'h74, 8'h3A, 8'h9D, 8'hCE, 8'hE7, 8'h73, 8'h39};

  // {wr, addr, data, expected active, expected base}
  localparam int NV = 40;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {1'b1,16'h0279,8'h86,1'b0,16'h0000},  // R2 base A
    {1'b1,16'h0279,8'h80,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h03F0},
    {1'b1,16'h03F0,8'h00,1'b0,16'h0000},  // R7 wrong first key byte
    {1'b1,16'h0279,8'h86,1'b0,16'h0000},  // R2 base B
    {1'b1,16'h0279,8'h80,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h0000},
    {1'b1,16'h0279,8'hAA,1'b0,16'h03BD},
    {1'b1,16'h03BD,8'h11,1'b0,16'h0000},  // R7
    {1'b1,16'h0279,8'h86,1'b0,16'h0000},  // R2 base C
    {1'b1,16'h0279,8'h80,1'b0,16'h0000},
    {1'b1,16'h0279,8'hAA,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h0370},
    {1'b1,16'h0370,8'h00,1'b0,16'h0000},  // R7
    {1'b1,16'h0279,8'h86,1'b0,16'h0000},  // R3 invalid selector
    {1'b1,16'h0279,8'h80,1'b0,16'h0000},
    {1'b1,16'h0279,8'hAA,1'b0,16'h0000},
    {1'b1,16'h0279,8'hAA,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h0000},
    {1'b1,16'h0279,8'h86,1'b0,16'h0000},  // R4 stray 0x86 resyncs
    {1'b1,16'h0279,8'h86,1'b0,16'h0000},
    {1'b1,16'h0279,8'h80,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h03F0},
    {1'b1,16'h0080,8'h86,1'b0,16'h03F0},  // R5 other port in key stage
    {1'b0,16'h03F0,8'h00,1'b0,16'h03F0},  // R5 no strobe
    {1'b1,16'h0279,8'h86,1'b0,16'h03F0},  // R5 unlock port in key stage
    {1'b1,16'h03F0,8'h00,1'b0,16'h0000},  // R7
    {1'b1,16'h0279,8'h86,1'b0,16'h0000},  // R5 other port in preamble
    {1'b1,16'h02F8,8'h00,1'b0,16'h0000},
    {1'b1,16'h0279,8'h80,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h03F0},
    {1'b1,16'h03F0,8'hFF,1'b0,16'h0000},  // R7
    {1'b1,16'h0279,8'h86,1'b0,16'h0000},  // R4 non-0x86 mismatch restarts
    {1'b1,16'h0279,8'h12,1'b0,16'h0000},
    {1'b1,16'h0279,8'h80,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h0000},
    {1'b1,16'h0279,8'h55,1'b0,16'h0000}};

  task automatic step(input logic w, input logic [15:0] a, input logic [7:0] d,
                      input logic ex);
    io_wr = w; io_addr = a; io_data = d; cfg_exit = ex;
    @(negedge clk);
    io_wr = 1'b0; cfg_exit = 1'b0;
  endtask

  task automatic check(input string req, input logic exp_act, input logic [15:0] exp_base);
    n_tests++;
    if (cfg_active !== exp_act || base_addr !== exp_base) begin
      n_fail++;
      $display("FAIL %s: active=%0b base=%h expected active=%0b base=%h",
               req, cfg_active, base_addr, exp_act, exp_base);
    end
  endtask

  task automatic preamble(input logic [7:0] s0, input logic [7:0] s1);
    step(1'b1, 16'h0279, 8'h86, 1'b0);
    step(1'b1, 16'h0279, 8'h80, 1'b0);
    step(1'b1, 16'h0279, s0, 1'b0);
    step(1'b1, 16'h0279, s1, 1'b0);
  endtask

  // Full unlock with a check before and after the final key byte (R6).
  task automatic unlock(input logic [7:0] s0, input logic [7:0] s1,
                        input logic [15:0] b, input bit noise);
    preamble(s0, s1);
    check("R2 base after preamble", 1'b0, b);
    for (int i = 0; i < 32; i++) begin
      step(1'b1, b, KEY[i], 1'b0);
      if (i == 30) check("R6 no unlock after 31 bytes", 1'b0, b);
      if (noise && i < 31) begin
        step(1'b1, b + 16'h1, 8'h00, 1'b0);
        step(1'b1, 16'h0279, 8'h86, 1'b0);
      end
    end
    check(noise ? "R5 key with interleaved writes" : "R6 unlock", 1'b1, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: active=%0b base=%h expected finish", cfg_active, base_addr);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    io_wr = 1'b1; io_addr = 16'h0279; io_data = 8'h86;
    @(negedge clk);
    io_wr = 1'b0;
    check("R1 reset state", 1'b0, 16'h0000);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][41], VEC[v][40:25], VEC[v][24:17], 1'b0);
      n_tests++;
      if (cfg_active !== VEC[v][16] || base_addr !== VEC[v][15:0]) begin
        n_fail++;
        $display("FAIL vector %0d (R2/R3/R4/R5/R7 table): active=%0b base=%h expected active=%0b base=%h",
                 v, cfg_active, base_addr, VEC[v][16], VEC[v][15:0]);
      end
    end

    // R6 then R8 then R9 on base A
    unlock(8'h55, 8'h55, 16'h03F0, 1'b0);
    step(1'b1, 16'h0279, 8'h86, 1'b0);
    step(1'b1, 16'h03F0, 8'h6A, 1'b0);
    step(1'b1, 16'h03F1, 8'h02, 1'b0);
    check("R8 writes ignored in config", 1'b1, 16'h03F0);
    step(1'b0, 16'h0000, 8'h00, 1'b1);
    check("R9 exit clears", 1'b0, 16'h0000);
    step(1'b1, 16'h03F0, 8'h6A, 1'b0);
    check("R9 no relock after exit", 1'b0, 16'h0000);

    // R6 on base B, R1 reset while in config on base C
    unlock(8'h55, 8'hAA, 16'h03BD, 1'b0);
    step(1'b0, 16'h0000, 8'h00, 1'b1);
    unlock(8'hAA, 8'h55, 16'h0370, 1'b0);
    rst = 1'b1;
    step(1'b0, 16'h0000, 8'h00, 1'b0);
    rst = 1'b0;
    check("R1 reset from config", 1'b0, 16'h0000);

    // R7 wrong final key byte
    preamble(8'h55, 8'h55);
    for (int i = 0; i < 31; i++) step(1'b1, 16'h03F0, KEY[i], 1'b0);
    step(1'b1, 16'h03F0, 8'h38, 1'b0);
    check("R7 wrong last key byte", 1'b0, 16'h0000);
    step(1'b1, 16'h03F0, 8'h39, 1'b0);
    check("R7 late right byte ignored", 1'b0, 16'h0000);

    // R9 exit in the middle of the key
    preamble(8'h55, 8'h55);
    for (int i = 0; i < 10; i++) step(1'b1, 16'h03F0, KEY[i], 1'b0);
    step(1'b0, 16'h0000, 8'h00, 1'b1);
    check("R9 exit mid key", 1'b0, 16'h0000);
    for (int i = 10; i < 32; i++) step(1'b1, 16'h03F0, KEY[i], 1'b0);
    check("R9 rest of key alone", 1'b0, 16'h0000);

    // R9 exit in the middle of the preamble
    step(1'b1, 16'h0279, 8'h86, 1'b0);
    step(1'b1, 16'h0279, 8'h80, 1'b0);
    step(1'b0, 16'h0000, 8'h00, 1'b1);
    step(1'b1, 16'h0279, 8'h55, 1'b0);
    step(1'b1, 16'h0279, 8'h55, 1'b0);
    check("R9 exit mid preamble", 1'b0, 16'h0000);

    // R5 key bytes interleaved with base+1 and unlock-port writes
    unlock(8'h55, 8'h55, 16'h03F0, 1'b1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule